// File: doc/BRIEF.md
# Register-Mapped Reset Line Controller

This peripheral drives a set of reset outputs (256 by default) from a small 32-bit register bus. The lines are split into banks of 32, and line `n` lives in bank `n/32` at bit `n%32`. Software has two independent ways to act on any line. It can hold the line with a persistent, active-low level bit. Or it can fire a self-timed one-shot pulse by writing a one to that line's bit in a write-only-style pulse register.

The two sources are merged per line into one registered, active-high reset output. After power-on reset every level bit is clear, so every line stays in reset until software releases it. The pulse registers read back which lines currently have a pulse in flight. The level registers read back their stored value, so one line can be changed by read-modify-write without touching its neighbours.

Top module: `rstctl_top`

## Requirements
- R1: After reset, every level register reads 0, every pulse register reads 0 and every bit of `rst_out` is 1.
- R2: Line `n` is bank `n/32`, bit `n%32`, and drives `rst_out[n]`.
- R3: The pulse register of bank `b` is at byte address `b*4`. A write sets `rst_out` high for each line written with a 1, from the cycle after the write edge, for exactly `PULSE_CYCLES` cycles (default 16).
- R4: A bit written as 0 in a pulse register leaves that line's pulse state unchanged. An active pulse keeps running and an idle line stays idle.
- R5: Writing a 1 to a line whose pulse is still active restarts its count, so the pulse lasts `PULSE_CYCLES` cycles from the newest write.
- R6: The level register of bank `b` is at byte address `0x7C + b*4` and is read/write. A write changes only that bank, and a read returns the stored word.
- R7: A read of a pulse register returns a 1 for each line of that bank whose pulse is active.
- R8: `rst_out[n]` is registered and equals NOT level bit OR pulse active. It follows a level write in the cycle after the write edge, and a 1 level bit with no pulse gives 0.
- R9: An address outside both register ranges, or one with `bus_addr[1:0]` not zero, reads as 0. A write to such an address changes no register and no output.
- R10: `bus_rdata` is combinational from `bus_addr` and the current register state, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| rst_out | output | NUM_BANKS*DATA_W (256) | Active-high reset lines |

## Verification
The bench sweeps every one of the 256 lines with a single-bit pulse. It requires exactly that one output bit to rise, which catches a swapped bank index or bit order. It counts the pulse width cycle by cycle, so an off-by-one counter shows up as a pulse one cycle too long or too short. It re-fires a line in mid-pulse to catch a design that ignores the rewrite or lets the old count run out. It also writes zeros over a running pulse to catch a design that cancels it. Finally it writes all ones to the gap between the two ranges, to the addresses just past each range and to unaligned addresses, then reads every register back. A decoder that aliases or drops the low address bits would corrupt a bank and fail that readback.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    // Byte address where the level register block begins; banks are word-spaced.
    localparam int unsigned LEVEL_BASE = 'h7C;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PULSE = 2'd1,
        SEL_LEVEL = 2'd2
    } sel_e;

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
    import rstctl_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output sel_e                 sel,
    output logic [BANK_W-1:0]    bank_idx,
    output logic [NUM_BANKS-1:0] pulse_we,
    output logic [NUM_BANKS-1:0] level_we
);

    localparam logic [ADDR_W:0]   PULSE_END = (ADDR_W+1)'(NUM_BANKS * 4);
    localparam logic [ADDR_W:0]   LVL_START = (ADDR_W+1)'(LEVEL_BASE);
    localparam logic [ADDR_W:0]   LVL_END   = (ADDR_W+1)'(LEVEL_BASE + NUM_BANKS * 4);
    localparam logic [ADDR_W-1:0] LVL_OFS   = ADDR_W'(LEVEL_BASE);

    typedef struct packed {
        sel_e                 sel;
        logic [BANK_W-1:0]    idx;
        logic [NUM_BANKS-1:0] pwe;
        logic [NUM_BANKS-1:0] lwe;
    } dec_t;

    dec_t dec_d;
    logic [ADDR_W:0]   addr_x;
    logic [ADDR_W-1:0] lvl_off;
    logic              aligned;

    always_comb begin
        addr_x  = {1'b0, addr};
        lvl_off = addr - LVL_OFS;
        aligned = (addr[1:0] == 2'b00);
        dec_d   = '{sel: SEL_NONE, idx: '0, pwe: '0, lwe: '0};
        if (aligned && (addr_x < PULSE_END)) begin
            dec_d.sel = SEL_PULSE;
            dec_d.idx = addr[BANK_W+1:2];
        end else if (aligned && (addr_x >= LVL_START) && (addr_x < LVL_END)) begin
            dec_d.sel = SEL_LEVEL;
            dec_d.idx = lvl_off[BANK_W+1:2];
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (we && (dec_d.idx == BANK_W'(b))) begin
                dec_d.pwe[b] = (dec_d.sel == SEL_PULSE);
                dec_d.lwe[b] = (dec_d.sel == SEL_LEVEL);
            end
        end
    end

    assign sel      = dec_d.sel;
    assign bank_idx = dec_d.idx;
    assign pulse_we = dec_d.pwe;
    assign level_we = dec_d.lwe;

endmodule

// File: rtl/rstctl_bank.sv
module rstctl_bank #(
    parameter int unsigned LINE_W       = 32,
    parameter int unsigned PULSE_CYCLES = 16,
    localparam int unsigned CNT_W       = $clog2(PULSE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_wr,
    input  logic              level_wr,
    input  logic [LINE_W-1:0] wdata,
    output logic [LINE_W-1:0] level_o,
    output logic [LINE_W-1:0] pulse_act_o,
    output logic [LINE_W-1:0] rst_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [LINE_W-1:0]            level;
        logic [LINE_W-1:0][CNT_W-1:0] cnt;
        logic [LINE_W-1:0]            rst;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (level_wr) begin
            st_d.level = wdata;
        end
        for (int i = 0; i < LINE_W; i++) begin
            if (pulse_wr && wdata[i]) begin
                st_d.cnt[i] = CNT_LOAD;
            end else if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - CNT_ONE;
            end
            st_d.rst[i] = ~st_d.level[i] | (st_d.cnt[i] != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= '0;
            st_q.cnt   <= '0;
            st_q.rst   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < LINE_W; i++) begin
            pulse_act_o[i] = (st_q.cnt[i] != '0);
        end
    end

    assign level_o = st_q.level;
    assign rst_o   = st_q.rst;

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_wr |=> ((rst_o & $past(wdata)) == $past(wdata)));                          // R3
    AST_ZERO_BIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_wr |=> ((pulse_act_o & ~$past(wdata) & ~$past(pulse_act_o)) == '0));      // R4
    AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_wr |=> ((pulse_act_o & $past(wdata)) == $past(wdata)));                    // R5
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !level_wr |=> $stable(level_o));                                                  // R6
    AST_IDLE_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_wr && !level_wr && (pulse_act_o == '0)) |=> (rst_o == ~level_o));        // R8

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int unsigned NUM_BANKS    = 8,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned PULSE_CYCLES = 16,
    parameter int unsigned ADDR_W       = 8,
    localparam int unsigned NUM_LINES   = NUM_BANKS * DATA_W,
    localparam int unsigned BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] rst_out
);

    sel_e                 sel;
    logic [BANK_W-1:0]    bank_idx;
    logic [NUM_BANKS-1:0] pulse_we;
    logic [NUM_BANKS-1:0] level_we;
    logic [DATA_W-1:0]    level_all [NUM_BANKS];
    logic [DATA_W-1:0]    pulse_all [NUM_BANKS];

    rstctl_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .we       (bus_we),
        .sel      (sel),
        .bank_idx (bank_idx),
        .pulse_we (pulse_we),
        .level_we (level_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rstctl_bank #(
            .LINE_W       (DATA_W),
            .PULSE_CYCLES (PULSE_CYCLES)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .pulse_wr    (pulse_we[b]),
            .level_wr    (level_we[b]),
            .wdata       (bus_wdata),
            .level_o     (level_all[b]),
            .pulse_act_o (pulse_all[b]),
            .rst_o       (rst_out[b*DATA_W +: DATA_W])
        );
    end

    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_W'(b)) begin
                if (sel == SEL_PULSE) rdata_d = pulse_all[b];
                if (sel == SEL_LEVEL) rdata_d = level_all[b];
            end
        end
    end

    assign bus_rdata = rdata_d;

    AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pulse_we, level_we}));                                                  // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0));                                         // R9
    AST_NO_STROBE_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> ((pulse_we == '0) && (level_we == '0)));                   // R9

endmodule

// File: tb/rstctl_top_tb.sv
module rstctl_top_tb;

    localparam int NB    = 8;
    localparam int DW    = 32;
    localparam int PC    = 16;
    localparam int AW    = 8;
    localparam int NL    = NB * DW;
    localparam int LBASE = 'h7C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NL-1:0] rst_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] lvl_exp [NB];

    always #4 clk = ~clk;

    rstctl_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_out   (rst_out)
    );

    task automatic chk(input bit ok, input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        bus_addr  = AW'(addr);
        bus_wdata = data;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [DW-1:0] data);
        bus_addr = AW'(addr);
        #1;
        data = bus_rdata;
    endtask

    function automatic logic [NL-1:0] exp_levels_only();
        logic [NL-1:0] v;
        for (int b = 0; b < NB; b++) v[b*DW +: DW] = ~lvl_exp[b];
        return v;
    endfunction

    task automatic check_all_levels(input string req);
        logic [DW-1:0] r;
        for (int b = 0; b < NB; b++) begin
            rd(LBASE + b*4, r);
            chk(r == lvl_exp[b], req, NL'(r), NL'(lvl_exp[b]));
            rd(b*4, r);
            chk(r == '0, req, NL'(r), '0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        logic [NL-1:0] e;
        for (int b = 0; b < NB; b++) lvl_exp[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(rst_out == '1, "R1 outputs", rst_out, '1);
        check_all_levels("R1 registers");

        // R6/R8/R10: distinct pattern per bank, readback and output slices
        for (int b = 0; b < NB; b++) begin
            lvl_exp[b] = 32'h9E37_79B9 * (b + 1);
            wr(LBASE + b*4, lvl_exp[b]);
            chk(rst_out == exp_levels_only(), "R8 output after level write", rst_out, exp_levels_only());
        end
        check_all_levels("R6 level readback");

        // R6: read-modify-write of one bit in bank 2
        for (int b = 0; b < NB; b++) begin
            lvl_exp[b] = '1;
            wr(LBASE + b*4, '1);
        end
        chk(rst_out == '0, "R8 all released", rst_out, '0);
        rd(LBASE + 8, r);
        wr(LBASE + 8, r & ~(32'h1 << 7));
        lvl_exp[2] = r & ~(32'h1 << 7);
        e = '0; e[2*DW + 7] = 1'b1;
        chk(rst_out == e, "R6 single line held", rst_out, e);
        check_all_levels("R6 rmw others untouched");
        wr(LBASE + 8, '1);
        lvl_exp[2] = '1;

        // R3/R7: exact pulse width and pulse readback
        wr(3*4, 32'h0000_F00F);
        e = '0; e[3*DW +: DW] = 32'h0000_F00F;
        rd(3*4, r);
        chk(r == 32'h0000_F00F, "R7 pulse readback", NL'(r), NL'(32'h0000_F00F));
        for (int k = 1; k <= PC; k++) begin
            chk(rst_out == e, "R3 pulse high", rst_out, e);
            @(negedge clk);
        end
        chk(rst_out == '0, "R3 pulse ended", rst_out, '0);
        rd(3*4, r);
        chk(r == '0, "R7 pulse readback idle", NL'(r), '0);

        // R4: zero write does not cancel a running pulse nor start one
        wr(5*4, 32'h0000_0003);
        wr(5*4, 32'h0000_0000);
        e = '0; e[5*DW +: 2] = 2'b11;
        chk(rst_out == e, "R4 zero write keeps pulse", rst_out, e);
        rd(5*4, r);
        chk(r == 32'h3, "R4 pulse bits after zero write", NL'(r), NL'(32'h3));
        repeat (PC) @(negedge clk);
        chk(rst_out == '0, "R4 drains", rst_out, '0);

        // R5: restart mid-pulse
        wr(6*4, 32'h8000_0000);
        repeat (9) @(negedge clk);
        wr(6*4, 32'h8000_0000);
        e = '0; e[6*DW + 31] = 1'b1;
        for (int k = 1; k <= PC; k++) begin
            chk(rst_out == e, "R5 restarted pulse high", rst_out, e);
            @(negedge clk);
        end
        chk(rst_out == '0, "R5 restarted pulse ended", rst_out, '0);

        // R8: pulse over a held line leaves it held after expiry
        wr(LBASE, 32'hFFFF_FFFE);
        lvl_exp[0] = 32'hFFFF_FFFE;
        wr(0, 32'h0000_0003);
        repeat (PC) @(negedge clk);
        e = '0; e[0] = 1'b1;
        chk(rst_out == e, "R8 level holds after pulse", rst_out, e);
        wr(LBASE, '1);
        lvl_exp[0] = '1;

        // R2: every line, one at a time
        for (int n = 0; n < NL; n++) begin
            wr((n / DW) * 4, 32'h1 << (n % DW));
            e = '0; e[n] = 1'b1;
            chk(rst_out == e, $sformatf("R2 line %0d", n), rst_out, e);
            repeat (PC) @(negedge clk);
        end
        chk(rst_out == '0, "R2 sweep idle", rst_out, '0);

        // R9: undecoded and unaligned addresses
        for (int b = 0; b < NB; b++) begin
            lvl_exp[b] = 32'h5A5A_0000 | b;
            wr(LBASE + b*4, lvl_exp[b]);
        end
        foreach (lvl_exp[b]) e[b*DW +: DW] = ~lvl_exp[b];
        begin
            int bad [9] = '{'h20, 'h24, 'h78, 'h9C, 'h01, 'h02, 'h7D, 'h7E, 'hFC};
            foreach (bad[i]) begin
                wr(bad[i], '1);
                rd(bad[i], r);
                chk(r == '0, $sformatf("R9 read 0x%0h", bad[i]), NL'(r), '0);
                chk(rst_out == e, $sformatf("R9 outputs after 0x%0h", bad[i]), rst_out, e);
            end
        end
        check_all_levels("R9 registers untouched");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule